// File: doc/BRIEF.md
# Instruction Result Reuse Buffer

This block keeps the results of instructions that have already executed, so that a later dynamic instance of the same static instruction can commit the stored result and skip execution. Each entry is located by the instruction address. It records the result together with the names of the two source registers that produced it. Because reuse is not speculative, a reported hit must always be the value that execution would have produced.

A front-end stage presents the address and the two source register names of an instruction, plus a flag that says whether the operands are ready. The answer comes back in the same cycle: a hit flag and the stored result. When an instruction finishes executing, the insert port records it. Every architectural register write is also shown to the buffer. The buffer then drops, within that cycle, every entry that reads the written register, so no stale result can be reused. Storage is set-associative and has a tree pseudo-LRU victim choice for each set.

Top module: `reuse_buf`

## Requirements
- R1: After reset no lookup hits. Whenever the hit flag is low, the returned result is all zeros.
- R2: A lookup in the cycle after an insert, with the same address and the same source names, hits and returns the inserted result. The same address with a different tag (address plus 64 maps to the same set) misses.
- R3: A lookup whose first or second source register name differs from the stored name misses, even when the address matches.
- R4: A lookup with the operand-ready flag low never hits.
- R5: A register write clears every entry that names the written register as either source. Entries that name neither source keep hitting.
- R6: When an insert and a register write to one of that insert's sources fall in the same cycle, the write is applied first and the inserted entry stays valid.
- R7: A lookup in the same cycle as a register write to either of its source names does not hit.
- R8: Inserting an address that is already present overwrites that entry in place, including its result and source names, and displaces no other entry of the set.
- R9: An insert of a new address takes the lowest-numbered invalid way of its set first. When all ways are valid it takes the tree pseudo-LRU way. After four new addresses fill a 4-way set in order, the next new address displaces the first one filled, and the one after that displaces the third one filled.
- R10: Under a long mixed stream of lookups, inserts and register writes, every hit returns the value obtained by recomputing the instruction from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Address of the instruction being tested |
| lk_src_a | input | REG_W | First source register name of the lookup |
| lk_src_b | input | REG_W | Second source register name of the lookup |
| lk_opnd_rdy | input | 1 | Source operands are ready for the reuse test |
| lk_hit | output | 1 | A reusable result exists (combinational) |
| lk_result | output | DATA_W | Reusable result, zero on a miss |
| ins_valid | input | 1 | Record a completed instruction |
| ins_pc | input | PC_W | Address of the completed instruction |
| ins_src_a | input | REG_W | First source register name |
| ins_src_b | input | REG_W | Second source register name |
| ins_result | input | DATA_W | Computed result |
| wr_valid | input | 1 | Architectural register write observed |
| wr_reg | input | REG_W | Name of the written register |

## Verification
Name matching is swept over all 32 values of each source field against one stored entry, so only the exact pair can hit. Invalidation is swept over all 32 written registers, which separates a write that names a source from one that does not. Replacement is driven with a fill order whose pseudo-LRU victim differs from its lowest free way, so the two policies give different survivors. A long stream then mixes lookups, inserts and writes across more addresses than the buffer holds, and every hit is compared with a recomputation from a register-file model.

// File: rtl/reuse_buf_pkg.sv
package reuse_buf_pkg;

   // How an insert picks its destination way
   typedef enum logic [1:0] {
      FILL_SAME_PC = 2'd0,
      FILL_FREE    = 2'd1,
      FILL_EVICT   = 2'd2
   } fill_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rb_plru.sv
// Tree pseudo-LRU state, one tree per set. Each node points to the half
// that was touched less recently.
module rb_plru #(
   parameter int unsigned SETS  = 16,
   parameter int unsigned WAYS  = 4,
   localparam int unsigned SET_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS),
   localparam int unsigned NODES = WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] q_set,
   output logic [WAY_W-1:0] victim,
   input  logic             upd_en,
   input  logic [SET_W-1:0] upd_set,
   input  logic [WAY_W-1:0] upd_way
);

   logic [NODES-1:0] tree_q [SETS];
   logic [NODES-1:0] cur_tree;
   logic [NODES-1:0] tree_nx;

   // walk from the root following the node pointers
   always_comb begin : victim_walk
      int unsigned node;
      node     = 0;
      cur_tree = tree_q[q_set];
      victim   = '0;
      for (int l = 0; l < WAY_W; l++) begin
         victim[WAY_W-1-l] = cur_tree[node];
         node = 2 * node + 1 + {31'b0, cur_tree[node]};
      end
   end

   // point every node on the touched path away from the touched way
   always_comb begin : touch_path
      int unsigned node;
      node    = 0;
      tree_nx = tree_q[upd_set];
      for (int l = 0; l < WAY_W; l++) begin
         tree_nx[node] = ~upd_way[WAY_W-1-l];
         node = 2 * node + 1 + {31'b0, upd_way[WAY_W-1-l]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (upd_en) begin
         tree_q[upd_set] <= tree_nx;
      end
   end

endmodule

// File: rtl/rb_entry_store.sv
// Entry storage: valid bits with parallel invalidation snoop, a full read
// port for lookups and a tag-only probe port for inserts.
module rb_entry_store #(
   parameter int unsigned SETS   = 16,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned TAG_W  = 28,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned SET_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   // lookup read port
   input  logic [SET_W-1:0]             rd_set,
   output logic [WAYS-1:0]              rd_valid,
   output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
   output logic [WAYS-1:0][REG_W-1:0]   rd_src_a,
   output logic [WAYS-1:0][REG_W-1:0]   rd_src_b,
   output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
   // insert probe port
   input  logic [SET_W-1:0]             pr_set,
   output logic [WAYS-1:0]              pr_valid,
   output logic [WAYS-1:0][TAG_W-1:0]   pr_tag,
   // write port
   input  logic                         wr_en,
   input  logic [SET_W-1:0]             wr_set,
   input  logic [WAY_W-1:0]             wr_way,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [REG_W-1:0]             wr_src_a,
   input  logic [REG_W-1:0]             wr_src_b,
   input  logic [DATA_W-1:0]            wr_data,
   // register-write snoop
   input  logic                         kill_en,
   input  logic [REG_W-1:0]             kill_reg
);

   logic [WAYS-1:0]              valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
   logic [WAYS-1:0][REG_W-1:0]   srca_q  [SETS];
   logic [WAYS-1:0][REG_W-1:0]   srcb_q  [SETS];
   logic [WAYS-1:0][DATA_W-1:0]  data_q  [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [WAYS-1:0] fill_w;
      logic [WAYS-1:0] kill_w;
      logic            set_sel;

      assign set_sel = wr_en && (wr_set == SET_W'(s));

      always_comb begin
         for (int w = 0; w < WAYS; w++) begin
            fill_w[w] = set_sel && (wr_way == WAY_W'(w));
            kill_w[w] = kill_en && ((srca_q[s][w] == kill_reg) ||
                                    (srcb_q[s][w] == kill_reg));
         end
      end

      // kill applies first, a fill in the same cycle wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) valid_q[s] <= '0;
         else        valid_q[s] <= (valid_q[s] & ~kill_w) | fill_w;
      end

      always_ff @(posedge clk) begin
         if (set_sel) begin
            tag_q[s][wr_way]  <= wr_tag;
            srca_q[s][wr_way] <= wr_src_a;
            srcb_q[s][wr_way] <= wr_src_b;
            data_q[s][wr_way] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_valid = valid_q[rd_set];
      rd_tag   = tag_q[rd_set];
      rd_src_a = srca_q[rd_set];
      rd_src_b = srcb_q[rd_set];
      rd_data  = data_q[rd_set];
      pr_valid = valid_q[pr_set];
      pr_tag   = tag_q[pr_set];
   end

endmodule

// File: rtl/rb_way_match.sv
// Per-way reuse test: valid, tag and both source names must agree.
module rb_way_match #(
   parameter int unsigned WAYS   = 4,
   parameter int unsigned TAG_W  = 28,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 64
) (
   input  logic [WAYS-1:0]              e_valid,
   input  logic [WAYS-1:0][TAG_W-1:0]   e_tag,
   input  logic [WAYS-1:0][REG_W-1:0]   e_src_a,
   input  logic [WAYS-1:0][REG_W-1:0]   e_src_b,
   input  logic [WAYS-1:0][DATA_W-1:0]  e_data,
   input  logic [TAG_W-1:0]             q_tag,
   input  logic [REG_W-1:0]             q_src_a,
   input  logic [REG_W-1:0]             q_src_b,
   output logic                         any_hit,
   output logic [DATA_W-1:0]            hit_data
);

   logic [WAYS-1:0] full_hit;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign full_hit[w] = e_valid[w] && (e_tag[w] == q_tag) &&
                           (e_src_a[w] == q_src_a) && (e_src_b[w] == q_src_b);
   end

   // at most one way holds a given address, so an AND-OR select suffices
   always_comb begin
      hit_data = '0;
      for (int w = 0; w < WAYS; w++)
         hit_data = hit_data | ({DATA_W{full_hit[w]}} & e_data[w]);
   end

   assign any_hit = |full_hit;

endmodule

// File: rtl/reuse_buf.sv
module reuse_buf #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned PC_LSB = 2,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned SETS   = 16,
   parameter int unsigned WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [PC_W-1:0]   lk_pc,
   input  logic [REG_W-1:0]  lk_src_a,
   input  logic [REG_W-1:0]  lk_src_b,
   input  logic              lk_opnd_rdy,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_result,
   input  logic              ins_valid,
   input  logic [PC_W-1:0]   ins_pc,
   input  logic [REG_W-1:0]  ins_src_a,
   input  logic [REG_W-1:0]  ins_src_b,
   input  logic [DATA_W-1:0] ins_result,
   input  logic              wr_valid,
   input  logic [REG_W-1:0]  wr_reg
);
   import reuse_buf_pkg::*;

   localparam int unsigned SET_W = $clog2(SETS);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned TAG_W = PC_W - SET_W;

   // elaboration-time parameter checks
   if (SETS < 2 || !is_pow2(SETS)) begin : g_bad_sets
      $error("reuse_buf: SETS must be a power of two, at least 2");
   end
   if (WAYS < 2 || !is_pow2(WAYS)) begin : g_bad_ways
      $error("reuse_buf: WAYS must be a power of two, at least 2");
   end
   if (PC_W <= PC_LSB + SET_W) begin : g_bad_pc
      $error("reuse_buf: PC_W too small for the index field");
   end

   logic [SET_W-1:0] lk_set, ins_set;
   logic [TAG_W-1:0] lk_tag, ins_tag;

   // index/tag split; the low alignment bits fold into the tag
   if (PC_LSB == 0) begin : g_tag_plain
      assign lk_set  = lk_pc[SET_W-1:0];
      assign ins_set = ins_pc[SET_W-1:0];
      assign lk_tag  = lk_pc[PC_W-1:SET_W];
      assign ins_tag = ins_pc[PC_W-1:SET_W];
   end else begin : g_tag_split
      assign lk_set  = lk_pc[PC_LSB +: SET_W];
      assign ins_set = ins_pc[PC_LSB +: SET_W];
      assign lk_tag  = {lk_pc[PC_W-1:PC_LSB+SET_W], lk_pc[PC_LSB-1:0]};
      assign ins_tag = {ins_pc[PC_W-1:PC_LSB+SET_W], ins_pc[PC_LSB-1:0]};
   end

   logic [WAYS-1:0]              rd_valid, pr_valid;
   logic [WAYS-1:0][TAG_W-1:0]   rd_tag, pr_tag;
   logic [WAYS-1:0][REG_W-1:0]   rd_src_a, rd_src_b;
   logic [WAYS-1:0][DATA_W-1:0]  rd_data;
   logic [WAY_W-1:0]             fill_way, plru_way;
   logic                         match_any;
   logic [DATA_W-1:0]            match_data;

   rb_entry_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (lk_set),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_src_a (rd_src_a),
      .rd_src_b (rd_src_b),
      .rd_data  (rd_data),
      .pr_set   (ins_set),
      .pr_valid (pr_valid),
      .pr_tag   (pr_tag),
      .wr_en    (ins_valid),
      .wr_set   (ins_set),
      .wr_way   (fill_way),
      .wr_tag   (ins_tag),
      .wr_src_a (ins_src_a),
      .wr_src_b (ins_src_b),
      .wr_data  (ins_result),
      .kill_en  (wr_valid),
      .kill_reg (wr_reg)
   );

   rb_way_match #(
      .WAYS(WAYS), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)
   ) u_match (
      .e_valid  (rd_valid),
      .e_tag    (rd_tag),
      .e_src_a  (rd_src_a),
      .e_src_b  (rd_src_b),
      .e_data   (rd_data),
      .q_tag    (lk_tag),
      .q_src_a  (lk_src_a),
      .q_src_b  (lk_src_b),
      .any_hit  (match_any),
      .hit_data (match_data)
   );

   rb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_set   (ins_set),
      .victim  (plru_way),
      .upd_en  (ins_valid),
      .upd_set (ins_set),
      .upd_way (fill_way)
   );

   // insert way choice: same address, else lowest free, else pseudo-LRU
   fill_kind_e       fill_kind;
   logic [WAY_W-1:0] same_way, free_way;
   logic             same_found, free_found;

   always_comb begin
      same_way   = '0;
      same_found = 1'b0;
      free_way   = '0;
      free_found = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (pr_valid[w] && (pr_tag[w] == ins_tag)) begin
            same_way   = WAY_W'(w);
            same_found = 1'b1;
         end
         if (!pr_valid[w]) begin
            free_way   = WAY_W'(w);
            free_found = 1'b1;
         end
      end
      if (same_found)      fill_kind = FILL_SAME_PC;
      else if (free_found) fill_kind = FILL_FREE;
      else                 fill_kind = FILL_EVICT;
      case (fill_kind)
         FILL_SAME_PC: fill_way = same_way;
         FILL_FREE:    fill_way = free_way;
         default:      fill_way = plru_way;
      endcase
   end

   // a write to a source in the same cycle as the reuse test blocks reuse
   logic wr_clash;
   assign wr_clash  = wr_valid && ((wr_reg == lk_src_a) || (wr_reg == lk_src_b));
   assign lk_hit    = lk_valid && lk_opnd_rdy && match_any && !wr_clash;
   assign lk_result = lk_hit ? match_data : '0;

endmodule

// File: rtl/reuse_buf_chk.sv
module reuse_buf_chk #(
   parameter int unsigned PC_W   = 32,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [PC_W-1:0]   lk_pc,
   input logic [REG_W-1:0]  lk_src_a,
   input logic [REG_W-1:0]  lk_src_b,
   input logic              lk_opnd_rdy,
   input logic              lk_hit,
   input logic [DATA_W-1:0] lk_result,
   input logic              ins_valid,
   input logic [PC_W-1:0]   ins_pc,
   input logic [REG_W-1:0]  ins_src_a,
   input logic [REG_W-1:0]  ins_src_b,
   input logic [DATA_W-1:0] ins_result,
   input logic              wr_valid,
   input logic [REG_W-1:0]  wr_reg
);

   // R1
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_result == '0));

   // R4
   hit_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_valid && lk_opnd_rdy));

   // R7
   write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && wr_valid) |-> ((wr_reg != lk_src_a) && (wr_reg != lk_src_b)));

   // R5
   snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !ins_valid) |=>
         !(lk_hit && ((lk_src_a == $past(wr_reg)) || (lk_src_b == $past(wr_reg)))));

   // R2
   fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ins_valid) && lk_valid && lk_opnd_rdy && !wr_valid &&
       (lk_pc == $past(ins_pc)) && (lk_src_a == $past(ins_src_a)) &&
       (lk_src_b == $past(ins_src_b)))
      |-> (lk_hit && (lk_result == $past(ins_result))));

endmodule

bind reuse_buf reuse_buf_chk #(.PC_W(PC_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .lk_pc       (lk_pc),
   .lk_src_a    (lk_src_a),
   .lk_src_b    (lk_src_b),
   .lk_opnd_rdy (lk_opnd_rdy),
   .lk_hit      (lk_hit),
   .lk_result   (lk_result),
   .ins_valid   (ins_valid),
   .ins_pc      (ins_pc),
   .ins_src_a   (ins_src_a),
   .ins_src_b   (ins_src_b),
   .ins_result  (ins_result),
   .wr_valid    (wr_valid),
   .wr_reg      (wr_reg)
);

// File: tb/reuse_buf_bench.sv
module reuse_buf_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic [4:0]  lk_src_a = '0;
   logic [4:0]  lk_src_b = '0;
   logic        lk_opnd_rdy = 1'b0;
   logic        lk_hit;
   logic [63:0] lk_result;
   logic        ins_valid = 1'b0;
   logic [31:0] ins_pc = '0;
   logic [4:0]  ins_src_a = '0;
   logic [4:0]  ins_src_b = '0;
   logic [63:0] ins_result = '0;
   logic        wr_valid = 1'b0;
   logic [4:0]  wr_reg = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   reuse_buf u_reuse_buf (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_src_a(lk_src_a), .lk_src_b(lk_src_b),
      .lk_opnd_rdy(lk_opnd_rdy), .lk_hit(lk_hit), .lk_result(lk_result),
      .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_src_a(ins_src_a),
      .ins_src_b(ins_src_b), .ins_result(ins_result),
      .wr_valid(wr_valid), .wr_reg(wr_reg)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // all tasks start and end one time unit after a rising edge
   task automatic do_ins(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b,
                         input logic [63:0] d, input bit with_wr, input logic [4:0] wreg);
      ins_valid = 1'b1; ins_pc = pc; ins_src_a = a; ins_src_b = b; ins_result = d;
      wr_valid = with_wr; wr_reg = wreg;
      @(posedge clk); #1;
      ins_valid = 1'b0; wr_valid = 1'b0;
   endtask

   task automatic do_wr(input logic [4:0] r);
      wr_valid = 1'b1; wr_reg = r;
      @(posedge clk); #1;
      wr_valid = 1'b0;
   endtask

   task automatic look(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b,
                       input bit rdy, input bit with_wr, input logic [4:0] wreg,
                       output bit hit, output logic [63:0] data);
      lk_valid = 1'b1; lk_pc = pc; lk_src_a = a; lk_src_b = b; lk_opnd_rdy = rdy;
      wr_valid = with_wr; wr_reg = wreg;
      #1;
      hit = lk_hit; data = lk_result;
      @(posedge clk); #1;
      lk_valid = 1'b0; wr_valid = 1'b0;
   endtask

   // look and compare with an expected hit flag and, on a hit, a result
   task automatic expect_look(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b,
                              input bit exp_hit, input logic [63:0] exp_data, input string req);
      bit h;
      logic [63:0] d;
      look(pc, a, b, 1'b1, 1'b0, 5'd0, h, d);
      chk(h == exp_hit, req, {63'd0, h}, {63'd0, exp_hit});
      if (exp_hit) chk(d == exp_data, req, d, exp_data);
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   initial begin
      #(4 * 200000);
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      bit h;
      logic [63:0] d;
      logic [31:0] p0, p1;
      logic [63:0] rf [32];
      logic [31:0] seed;
      int hits;

      repeat (3) @(posedge clk);
      #1;
      // R1: nothing hits during or right after reset
      look(32'h2014, 5'd3, 5'd9, 1'b1, 1'b0, 5'd0, h, d);
      chk(!h, "R1 in reset", {63'd0, h}, 64'd0);
      chk(d == 64'd0, "R1 zero result", d, 64'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      look(32'h2014, 5'd3, 5'd9, 1'b1, 1'b0, 5'd0, h, d);
      chk(!h, "R1 after reset", {63'd0, h}, 64'd0);

      // R2: insert then hit; same set with another tag misses
      p0 = 32'h2014;          // set 5
      p1 = 32'h2014 + 32'h40; // set 5, other tag
      do_ins(p0, 5'd3, 5'd9, 64'hA5A5_0000_0000_0001, 1'b0, 5'd0);
      expect_look(p0, 5'd3, 5'd9, 1'b1, 64'hA5A5_0000_0000_0001, "R2 hit");
      expect_look(p1, 5'd3, 5'd9, 1'b0, 64'd0, "R2 tag miss");

      // R3: sweep every name of each source field
      for (int r = 0; r < 32; r++) begin
         expect_look(p0, 5'(r), 5'd9, (r == 3), 64'hA5A5_0000_0000_0001, "R3 src_a sweep");
         expect_look(p0, 5'd3, 5'(r), (r == 9), 64'hA5A5_0000_0000_0001, "R3 src_b sweep");
      end

      // R4: operands not ready
      look(p0, 5'd3, 5'd9, 1'b0, 1'b0, 5'd0, h, d);
      chk(!h, "R4 not ready", {63'd0, h}, 64'd0);
      chk(d == 64'd0, "R1 R4 zero on miss", d, 64'd0);

      // R5: sweep every written register
      for (int r = 0; r < 32; r++) begin
         do_ins(p0, 5'd3, 5'd9, 64'h5000 + 64'(r), 1'b0, 5'd0);
         do_wr(5'(r));
         expect_look(p0, 5'd3, 5'd9, !(r == 3 || r == 9), 64'h5000 + 64'(r), "R5 snoop sweep");
      end

      // R6: insert and write of its own source together
      do_ins(p0, 5'd3, 5'd9, 64'h6666, 1'b1, 5'd3);
      expect_look(p0, 5'd3, 5'd9, 1'b1, 64'h6666, "R6 insert wins");

      // R7: lookup alongside a write
      look(p0, 5'd3, 5'd9, 1'b1, 1'b1, 5'd12, h, d);
      chk(h, "R7 unrelated write", {63'd0, h}, 64'd1);
      chk(d == 64'h6666, "R7 unrelated write data", d, 64'h6666);
      look(p0, 5'd3, 5'd9, 1'b1, 1'b1, 5'd9, h, d);
      chk(!h, "R7 source write", {63'd0, h}, 64'd0);

      // R9: set 7, fill in order, then evict
      for (int k = 0; k < 4; k++)
         do_ins(32'h301C + 32'(k) * 32'h40, (k == 3) ? 5'd4 : 5'd1, 5'd2,
                64'd100 + 64'(k), 1'b0, 5'd0);
      do_ins(32'h301C + 32'd4 * 32'h40, 5'd1, 5'd2, 64'd104, 1'b0, 5'd0);
      expect_look(32'h301C, 5'd1, 5'd2, 1'b0, 64'd0, "R9 first filled evicted");
      expect_look(32'h305C, 5'd1, 5'd2, 1'b1, 64'd101, "R9 keep");
      do_ins(32'h301C + 32'd5 * 32'h40, 5'd1, 5'd2, 64'd105, 1'b0, 5'd0);
      expect_look(32'h309C, 5'd1, 5'd2, 1'b0, 64'd0, "R9 third filled evicted");
      expect_look(32'h305C, 5'd1, 5'd2, 1'b1, 64'd101, "R9 keep");
      expect_look(32'h30DC, 5'd4, 5'd2, 1'b1, 64'd103, "R9 keep");
      expect_look(32'h311C, 5'd1, 5'd2, 1'b1, 64'd104, "R9 keep");
      expect_look(32'h315C, 5'd1, 5'd2, 1'b1, 64'd105, "R9 keep");
      // free the fourth way; next new address must use it, not the LRU way
      do_wr(5'd4);
      do_ins(32'h301C + 32'd6 * 32'h40, 5'd1, 5'd2, 64'd106, 1'b0, 5'd0);
      expect_look(32'h305C, 5'd1, 5'd2, 1'b1, 64'd101, "R9 free way first");
      expect_look(32'h311C, 5'd1, 5'd2, 1'b1, 64'd104, "R9 free way first");
      expect_look(32'h315C, 5'd1, 5'd2, 1'b1, 64'd105, "R9 free way first");
      expect_look(32'h319C, 5'd1, 5'd2, 1'b1, 64'd106, "R9 free way first");

      // R8: set 9, refill an existing address in place
      for (int k = 0; k < 4; k++)
         do_ins(32'h4024 + 32'(k) * 32'h40, 5'd6, 5'd7, 64'd300 + 64'(k), 1'b0, 5'd0);
      do_ins(32'h4064, 5'd6, 5'd8, 64'd399, 1'b0, 5'd0);
      expect_look(32'h4064, 5'd6, 5'd8, 1'b1, 64'd399, "R8 overwritten");
      expect_look(32'h4064, 5'd6, 5'd7, 1'b0, 64'd0, "R8 old names gone");
      for (int k = 0; k < 4; k++)
         if (k != 1)
            expect_look(32'h4024 + 32'(k) * 32'h40, 5'd6, 5'd7, 1'b1,
                        64'd300 + 64'(k), "R8 others kept");

      // R10: mixed stream checked against a register-file model
      for (int r = 0; r < 32; r++) rf[r] = 64'(r) * 64'h1111_0000_1111;
      seed = 32'h1234_5677;
      hits = 0;
      for (int step = 0; step < 1500; step++) begin
         int i;
         logic [31:0] pc;
         logic [4:0]  a, b;
         logic [63:0] exp;
         seed = next_rand(seed);
         i  = int'(seed % 32'd96);
         pc = 32'h1000 + 32'(i) * 32'd4;
         a  = 5'((i * 7 + 1) % 24);
         b  = 5'((i * 11 + 2) % 24);
         exp = (rf[a] * 64'd3 + rf[b]) ^ {32'd0, pc};
         look(pc, a, b, 1'b1, 1'b0, 5'd0, h, d);
         if (h) begin
            hits++;
            chk(d == exp, "R10 hit equals recomputation", d, exp);
         end else begin
            do_ins(pc, a, b, exp, 1'b0, 5'd0);
         end
         if (step % 2 == 1) begin
            logic [4:0] dst;
            seed = next_rand(seed);
            dst = 5'd16 + 5'(seed % 32'd8);
            rf[dst] = exp + 64'(step);
            do_wr(dst);
         end
      end
      chk(hits > 0, "R10 reuse observed", 64'(hits), 64'd1);

      finish_run();
   end

endmodule